// File: doc/BRIEF.md
# Speculation ID Lifecycle Manager

This block owns a pool of short speculation tags that processor threads attach to speculative memory accesses. Each tag moves through a four-state life: free, in flight, thrown away or made permanent. Commit and abort change only the tag's entry in a state table, so they take effect in one cycle no matter how much cached data carries the tag. The cache directory tells the block, through increment and decrement pulses, how many directory entries still hold each tag. A thrown-away or committed tag goes back to the free pool only once that count is zero.

The tag space is split into domains by a base and a size per domain. Each domain keeps its own allocation pointer and its own mode, ordered or unordered. Tag age inside a domain is measured relative to the pointer, so ordering stays correct after the tag numbers wrap. In an ordered domain, aborting a tag also aborts every younger in-flight tag of that domain. A state lookup port serves tag matching, and an age-compare port answers older/younger queries.

Top module: `spec_id_mgr`

## Requirements
- R1: After reset every tag is free, every reference count is zero, `ref_err` is low, and each domain's pointer offset is zero, so the first allocation in a domain searches from its base.
- R2: `look_state` gives the current state of tag `look_id` in the same cycle. The encoding is: 0 free, 1 in flight, 2 aborted, 3 committed.
- R3: A request on `alloc_req` for domain `alloc_dom` is answered one cycle later on `alloc_done`, with `alloc_id` set to the first free tag of that domain. The search starts at base plus pointer offset and wraps within the domain. That tag becomes in flight, and the offset moves to one past it, wrapping to zero at the domain size.
- R4: When the requested domain has no free tag, `alloc_fail` is raised together with `alloc_done`, and no state or pointer changes.
- R5: A commit of an in-flight tag makes it committed at the next edge. `commit_done` follows every commit one cycle later. `commit_err` is raised with it when the tag was not in flight, and that tag's state is left unchanged.
- R6: An abort of an in-flight tag makes it aborted at the next edge. An abort of a tag in any other state has no effect.
- R7: In an ordered domain (`dom_ordered` bit set), an abort also marks as aborted every in-flight tag of the same domain whose age key is larger. In an unordered domain only the named tag changes. When a tag is committed and aborted in the same cycle, the abort wins.
- R8: A tag that is aborted or committed and has a reference count of zero becomes free at the next edge. A nonzero count holds it in place.
- R9: `ref_inc` and `ref_dec` each change the count of their tag by one. An increment stops at the counter maximum. An increment and a decrement of the same tag in the same cycle cancel each other.
- R10: A decrement of a tag whose count is zero (with no increment of the same tag in that cycle) sets the sticky `ref_err`, which only reset clears. The count stays at zero.
- R11: A tag belongs to the lowest-numbered domain d for which base(d) <= tag < base(d)+size(d). Its age key is (tag - base - offset) mod size, and a smaller key means older. `age_same` shows that both query tags map to one domain, and `age_a_older` that `age_a` has the smaller key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_base | input | NUM_DOM*IDW | First tag of each domain, packed per domain |
| dom_size | input | NUM_DOM*(IDW+1) | Tag count of each domain, packed per domain |
| dom_ordered | input | NUM_DOM | Per-domain ordered mode |
| alloc_req | input | 1 | Allocation request |
| alloc_dom | input | DW | Domain to allocate from |
| alloc_done | output | 1 | Allocation answered |
| alloc_fail | output | 1 | No free tag in the domain |
| alloc_id | output | IDW | Granted tag |
| commit_req | input | 1 | Commit command |
| commit_id | input | IDW | Tag to commit |
| commit_done | output | 1 | Commit answered |
| commit_err | output | 1 | Commit refused |
| abort_req | input | 1 | Abort command |
| abort_id | input | IDW | Tag to abort |
| ref_inc | input | 1 | Reference count increment pulse |
| ref_inc_id | input | IDW | Tag to increment |
| ref_dec | input | 1 | Reference count decrement pulse |
| ref_dec_id | input | IDW | Tag to decrement |
| ref_err | output | 1 | Sticky decrement-at-zero flag |
| look_id | input | IDW | Tag to look up |
| look_state | output | 2 | State of the looked-up tag |
| age_a | input | IDW | First tag of the age query |
| age_b | input | IDW | Second tag of the age query |
| age_same | output | 1 | Both tags in one domain |
| age_a_older | output | 1 | `age_a` is older than `age_b` |

## Verification
The bench builds the block with 16 tags, 4 domains and 3-bit counters. With so few tags, domains fill up, pointers wrap and counters saturate within a few hundred random cycles. The domain layout mixes an ordered domain of 6, an unordered domain of 4, an ordered domain of 5 and an empty domain, and it leaves tag 15 outside every domain. This brings allocation failure, tags that are never used, and cascades that cross a pointer wrap within reach.

// File: rtl/spec_id_mgr.sv
`timescale 1ns/1ps
module spec_id_mgr #(
  parameter int NUM_IDS = 128,
  parameter int NUM_DOM = 16,
  parameter int CNT_W   = 6
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [NUM_DOM*$clog2(NUM_IDS)-1:0]       dom_base,
  input  logic [NUM_DOM*($clog2(NUM_IDS)+1)-1:0]   dom_size,
  input  logic [NUM_DOM-1:0]                       dom_ordered,
  input  logic                                     alloc_req,
  input  logic [$clog2(NUM_DOM)-1:0]               alloc_dom,
  output logic                                     alloc_done,
  output logic                                     alloc_fail,
  output logic [$clog2(NUM_IDS)-1:0]               alloc_id,
  input  logic                                     commit_req,
  input  logic [$clog2(NUM_IDS)-1:0]               commit_id,
  output logic                                     commit_done,
  output logic                                     commit_err,
  input  logic                                     abort_req,
  input  logic [$clog2(NUM_IDS)-1:0]               abort_id,
  input  logic                                     ref_inc,
  input  logic [$clog2(NUM_IDS)-1:0]               ref_inc_id,
  input  logic                                     ref_dec,
  input  logic [$clog2(NUM_IDS)-1:0]               ref_dec_id,
  output logic                                     ref_err,
  input  logic [$clog2(NUM_IDS)-1:0]               look_id,
  output logic [1:0]                               look_state,
  input  logic [$clog2(NUM_IDS)-1:0]               age_a,
  input  logic [$clog2(NUM_IDS)-1:0]               age_b,
  output logic                                     age_same,
  output logic                                     age_a_older
);
  localparam int IDW = $clog2(NUM_IDS);
  localparam int DW  = $clog2(NUM_DOM);
  localparam int SW  = IDW + 1;
  localparam logic [1:0] S_FREE = 2'd0, S_SPEC = 2'd1, S_ABRT = 2'd2, S_DONE = 2'd3;

  logic [1:0]       st     [NUM_IDS];
  logic [CNT_W-1:0] cnt    [NUM_IDS];
  logic [IDW-1:0]   off    [NUM_DOM];
  logic             id_in  [NUM_IDS];
  logic [DW-1:0]    id_dom [NUM_IDS];
  logic [SW-1:0]    id_rel [NUM_IDS];
  logic [SW-1:0]    id_key [NUM_IDS];

  always_comb begin : map_ids
    logic [SW-1:0] oj, sj, bj;
    for (int j = 0; j < NUM_IDS; j++) begin
      id_in[j]  = 1'b0;
      id_dom[j] = '0;
      id_rel[j] = '0;
      for (int d = NUM_DOM - 1; d >= 0; d--) begin
        bj = SW'(dom_base[d*IDW +: IDW]);
        if (SW'(j) >= bj && (SW'(j) - bj) < dom_size[d*SW +: SW]) begin
          id_in[j]  = 1'b1;
          id_dom[j] = DW'(d);
          id_rel[j] = SW'(j) - bj;
        end
      end
      oj = {1'b0, off[id_dom[j]]};
      sj = dom_size[id_dom[j]*SW +: SW];
      id_key[j] = (id_rel[j] >= oj) ? id_rel[j] - oj : id_rel[j] + sj - oj;
    end
  end

  logic           a_hi, a_lo, a_ok;
  logic [IDW-1:0] a_hi_id, a_lo_id, a_pick;
  logic [SW-1:0]  a_ptr, a_sz, a_next;

  always_comb begin : alloc_search
    a_sz    = dom_size[alloc_dom*SW +: SW];
    a_ptr   = SW'(dom_base[alloc_dom*IDW +: IDW]) + {1'b0, off[alloc_dom]};
    a_hi    = 1'b0;
    a_lo    = 1'b0;
    a_hi_id = '0;
    a_lo_id = '0;
    for (int j = NUM_IDS - 1; j >= 0; j--) begin
      if (st[j] == S_FREE && id_in[j] && id_dom[j] == alloc_dom) begin
        if (SW'(j) >= a_ptr) begin
          a_hi    = 1'b1;
          a_hi_id = IDW'(j);
        end else begin
          a_lo    = 1'b1;
          a_lo_id = IDW'(j);
        end
      end
    end
    a_ok   = a_hi | a_lo;
    a_pick = a_hi ? a_hi_id : a_lo_id;
    a_next = id_rel[a_pick] + 1'b1;
    if (a_next == a_sz) a_next = '0;
  end

  logic cm_ok, ab_ok, ab_chain, dec_zero;
  assign cm_ok    = commit_req && st[commit_id] == S_SPEC;
  assign ab_ok    = abort_req && st[abort_id] == S_SPEC;
  assign ab_chain = ab_ok && id_in[abort_id] && dom_ordered[id_dom[abort_id]];
  assign dec_zero = ref_dec && !(ref_inc && ref_inc_id == ref_dec_id) && cnt[ref_dec_id] == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_IDS; j++) begin
        st[j]  <= S_FREE;
        cnt[j] <= '0;
      end
      for (int d = 0; d < NUM_DOM; d++) off[d] <= '0;
      ref_err     <= 1'b0;
      alloc_done  <= 1'b0;
      alloc_fail  <= 1'b0;
      alloc_id    <= '0;
      commit_done <= 1'b0;
      commit_err  <= 1'b0;
    end else begin
      for (int j = 0; j < NUM_IDS; j++) begin
        case (st[j])
          S_FREE: if (alloc_req && a_ok && a_pick == IDW'(j)) st[j] <= S_SPEC;
          S_SPEC: begin
            if (ab_ok && (abort_id == IDW'(j) ||
                (ab_chain && id_in[j] && id_dom[j] == id_dom[abort_id] && id_key[j] > id_key[abort_id])))
              st[j] <= S_ABRT;
            else if (cm_ok && commit_id == IDW'(j))
              st[j] <= S_DONE;
          end
          default: if (cnt[j] == '0) st[j] <= S_FREE;
        endcase
        if (ref_inc && ref_inc_id == IDW'(j) && !(ref_dec && ref_dec_id == IDW'(j))) begin
          if (cnt[j] != '1) cnt[j] <= cnt[j] + 1'b1;
        end else if (ref_dec && ref_dec_id == IDW'(j) && !(ref_inc && ref_inc_id == IDW'(j))) begin
          if (cnt[j] != '0) cnt[j] <= cnt[j] - 1'b1;
        end
      end
      if (alloc_req && a_ok) off[alloc_dom] <= IDW'(a_next);
      ref_err     <= ref_err | dec_zero;
      alloc_done  <= alloc_req;
      alloc_fail  <= alloc_req && !a_ok;
      alloc_id    <= a_pick;
      commit_done <= commit_req;
      commit_err  <= commit_req && !cm_ok;
    end
  end

  assign look_state  = st[look_id];
  assign age_same    = id_in[age_a] && id_in[age_b] && id_dom[age_a] == id_dom[age_b];
  assign age_a_older = age_same && id_key[age_a] < id_key[age_b];
endmodule

module spec_id_mgr_chk #(parameter int IDW = 7) (
  input logic           clk,
  input logic           rst_n,
  input logic           alloc_req,
  input logic           alloc_done,
  input logic           alloc_fail,
  input logic           commit_req,
  input logic           commit_done,
  input logic           commit_err,
  input logic           ref_err,
  input logic [IDW-1:0] age_a,
  input logic [IDW-1:0] age_b,
  input logic           age_same,
  input logic           age_a_older
);
  assert_done_tracks_req_R3: assert property (@(posedge clk) disable iff (!rst_n) alloc_req |=> alloc_done);
  assert_no_stray_done_R3:   assert property (@(posedge clk) disable iff (!rst_n) !alloc_req |=> !alloc_done);
  assert_fail_with_done_R4:  assert property (@(posedge clk) disable iff (!rst_n) alloc_fail |-> alloc_done);
  assert_commit_answer_R5:   assert property (@(posedge clk) disable iff (!rst_n) commit_req |=> commit_done);
  assert_cerr_with_done_R5:  assert property (@(posedge clk) disable iff (!rst_n) commit_err |-> commit_done);
  assert_err_sticky_R10:     assert property (@(posedge clk) disable iff (!rst_n) ref_err |=> ref_err);
  assert_older_same_dom_R11: assert property (@(posedge clk) disable iff (!rst_n) age_a_older |-> age_same);
  assert_self_not_older_R11: assert property (@(posedge clk) disable iff (!rst_n) (age_a == age_b) |-> !age_a_older);
endmodule

bind spec_id_mgr spec_id_mgr_chk #(.IDW($clog2(NUM_IDS))) u_chk (.*);

// File: tb/sim_spec_id_mgr.sv
`timescale 1ns/1ps
module sim_spec_id_mgr;
  localparam int N = 16, D = 4, C = 3, IW = 4, DWB = 2, SW = 5;
  localparam int CMAX = (1 << C) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [D*IW-1:0] dom_base;
  logic [D*SW-1:0] dom_size;
  logic [D-1:0]    dom_ordered;
  logic alloc_req = 0, commit_req = 0, abort_req = 0, ref_inc = 0, ref_dec = 0;
  logic [DWB-1:0] alloc_dom = 0;
  logic [IW-1:0] commit_id = 0, abort_id = 0, ref_inc_id = 0, ref_dec_id = 0, look_id = 0, age_a = 0, age_b = 0;
  logic alloc_done, alloc_fail, commit_done, commit_err, ref_err, age_same, age_a_older;
  logic [IW-1:0] alloc_id;
  logic [1:0] look_state;

  spec_id_mgr #(.NUM_IDS(N), .NUM_DOM(D), .CNT_W(C)) u0 (.*);

  int cb[D] = '{0, 6, 10, 15};
  int cs[D] = '{6, 4, 5, 0};
  bit co[D] = '{1'b1, 1'b0, 1'b1, 1'b0};
  int m_st[N], m_cnt[N], m_off[D];
  bit m_err, e_adone, e_afail, e_cdone, e_cerr, done;
  int e_aid, n_chk, n_err;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dom_of(int id);
    for (int d = 0; d < D; d++) if (id >= cb[d] && id < cb[d] + cs[d]) return d;
    return -1;
  endfunction

  function automatic int key(int id);
    int d = dom_of(id);
    return (id - cb[d] - m_off[d] + cs[d]) % cs[d];
  endfunction

  task automatic model_step();
    int n_st[N];
    int pick = -1, d = int'(alloc_dom), da = dom_of(int'(abort_id));
    bit cm, ab;
    if (alloc_req)
      for (int k = 0; k < cs[d]; k++) begin
        int id = cb[d] + (m_off[d] + k) % cs[d];
        if (m_st[id] == 0) begin pick = id; break; end
      end
    cm = commit_req && m_st[commit_id] == 1;
    ab = abort_req && m_st[abort_id] == 1;
    for (int j = 0; j < N; j++) begin
      n_st[j] = m_st[j];
      if (m_st[j] == 0 && j == pick) n_st[j] = 1;
      else if (m_st[j] == 1) begin
        if (ab && (j == int'(abort_id) || (da >= 0 && co[da] && dom_of(j) == da && key(j) > key(int'(abort_id)))))
          n_st[j] = 2;
        else if (cm && j == int'(commit_id)) n_st[j] = 3;
      end else if (m_st[j] >= 2 && m_cnt[j] == 0) n_st[j] = 0;
    end
    if (ref_dec && !(ref_inc && ref_inc_id == ref_dec_id) && m_cnt[ref_dec_id] == 0) m_err = 1;
    if (!(ref_inc && ref_dec && ref_inc_id == ref_dec_id)) begin
      if (ref_inc && m_cnt[ref_inc_id] < CMAX) m_cnt[ref_inc_id]++;
      if (ref_dec && m_cnt[ref_dec_id] > 0) m_cnt[ref_dec_id]--;
    end
    for (int j = 0; j < N; j++) m_st[j] = n_st[j];
    if (pick >= 0) m_off[d] = (pick - cb[d] + 1) % cs[d];
    e_adone = alloc_req;
    e_afail = alloc_req && pick < 0;
    if (pick >= 0) e_aid = pick;
    e_cdone = commit_req;
    e_cerr  = commit_req && !cm;
  endtask

  task automatic check_all();
    int da, db;
    chk("R3 alloc_done", alloc_done, e_adone);
    if (e_adone) chk("R4 alloc_fail", alloc_fail, e_afail);
    if (e_adone && !e_afail) chk("R3 alloc_id", alloc_id, e_aid);
    chk("R5 commit_done", commit_done, e_cdone);
    if (e_cdone) chk("R5 commit_err", commit_err, e_cerr);
    chk("R10 ref_err", ref_err, m_err);
    for (int j = 0; j < N; j++) begin
      look_id = IW'(j);
      #0.1;
      chk("R2 look_state", look_state, m_st[j]);
    end
    age_a = IW'($urandom % N);
    age_b = IW'($urandom % N);
    #0.1;
    da = dom_of(int'(age_a));
    db = dom_of(int'(age_b));
    chk("R11 age_same", age_same, (da >= 0 && da == db));
    chk("R11 age_a_older", age_a_older, (da >= 0 && da == db && key(int'(age_a)) < key(int'(age_b))));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
    alloc_req = 0; commit_req = 0; abort_req = 0; ref_inc = 0; ref_dec = 0;
  endtask

  task automatic expect_state(int id, int exp, string tag);
    look_id = IW'(id);
    #0.1;
    chk(tag, look_state, exp);
  endtask

  task automatic do_alloc(int d);   alloc_req = 1; alloc_dom = DWB'(d); tick(); endtask
  task automatic do_commit(int id); commit_req = 1; commit_id = IW'(id); tick(); endtask
  task automatic do_abort(int id);  abort_req = 1; abort_id = IW'(id); tick(); endtask
  task automatic do_inc(int id);    ref_inc = 1; ref_inc_id = IW'(id); tick(); endtask
  task automatic do_dec(int id);    ref_dec = 1; ref_dec_id = IW'(id); tick(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7193));
    for (int d = 0; d < D; d++) begin
      dom_base[d*IW +: IW] = IW'(cb[d]);
      dom_size[d*SW +: SW] = SW'(cs[d]);
      dom_ordered[d] = co[d];
    end
    for (int j = 0; j < N; j++) begin m_st[j] = 0; m_cnt[j] = 0; end
    for (int d = 0; d < D; d++) m_off[d] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 ref_err low", ref_err, 0);
    chk("R1 alloc_done low", alloc_done, 0);
    for (int j = 0; j < N; j++) expect_state(j, 0, "R1 free after reset");

    do_alloc(0); chk("R3 first tag at base", alloc_id, 0);
    do_alloc(0); chk("R3 second tag", alloc_id, 1);
    do_alloc(0); chk("R3 third tag", alloc_id, 2);
    do_inc(1); do_inc(1);
    age_a = 0; age_b = 2; #0.1; chk("R11 older tag", age_a_older, 1);
    age_a = 2; age_b = 0; #0.1; chk("R11 younger tag", age_a_older, 0);
    age_a = 0; age_b = 7; #0.1; chk("R11 cross domain", age_same, 0);

    do_abort(1);
    expect_state(1, 2, "R6 abort");
    expect_state(2, 2, "R7 cascade younger");
    expect_state(0, 1, "R7 older untouched");
    tick();
    expect_state(2, 0, "R8 reclaim at zero");
    expect_state(1, 2, "R8 held by references");
    do_dec(1); do_dec(1);
    expect_state(1, 2, "R8 count just reached zero");
    tick();
    expect_state(1, 0, "R8 reclaim after release");

    do_alloc(1); chk("R1 pointer starts at base", alloc_id, 6);
    do_alloc(1); chk("R3 next in domain", alloc_id, 7);
    do_abort(6);
    expect_state(7, 1, "R7 unordered no cascade");
    do_commit(0); expect_state(0, 3, "R5 commit");
    tick();       expect_state(0, 0, "R8 committed reclaimed");
    do_commit(0); chk("R5 commit refused", commit_err, 1);
    commit_req = 1; commit_id = 7; abort_req = 1; abort_id = 7; tick();
    expect_state(7, 2, "R7 abort wins over commit");
    do_abort(3);  expect_state(3, 0, "R6 abort of free tag ignored");
    do_alloc(3);  chk("R4 empty domain fails", alloc_fail, 1);

    do_alloc(1); chk("R3 pointer advanced", alloc_id, 8);
    for (int i = 0; i < 9; i++) do_inc(8);
    do_commit(8);
    for (int i = 0; i < 6; i++) do_dec(8);
    expect_state(8, 3, "R9 saturated count holds tag");
    do_dec(8); tick();
    expect_state(8, 0, "R9 count drained at maximum");
    ref_inc = 1; ref_inc_id = 9; ref_dec = 1; ref_dec_id = 9; tick();
    chk("R9 same-tag inc and dec cancel", ref_err, 0);
    do_dec(5); chk("R10 underflow flagged", ref_err, 1);
    tick();    chk("R10 flag sticky", ref_err, 1);

    for (int i = 0; i < 3000; i++) begin
      alloc_req = ($urandom % 2) == 0;
      alloc_dom = DWB'($urandom % D);
      commit_req = ($urandom % 4) == 0;
      commit_id = IW'($urandom % N);
      abort_req = ($urandom % 8) == 0;
      abort_id = IW'($urandom % N);
      ref_inc = ($urandom % 3) == 0;
      ref_inc_id = IW'($urandom % N);
      ref_dec = ($urandom % 3) == 0;
      ref_dec_id = IW'($urandom % N);
      if ($urandom % 2)
        for (int k = 0; k < N; k++)
          if (m_cnt[(int'(ref_dec_id) + k) % N] > 0) begin
            ref_dec_id = IW'((int'(ref_dec_id) + k) % N);
            break;
          end
      tick();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule